// File: doc/BRIEF.md
# SPI Host Command Transaction Engine

This block runs one complete register or command transaction from the host side of a byte-wide SPI link. A caller supplies an opcode, a 24-bit address, a 32-bit write word, a 24-bit length, a CRC-enable flag and a clockless flag, and pulses `start_i`. The engine lays out the command frame that the opcode calls for. It can append a CRC7 check byte. It then keeps the link running with zero filler bytes, and it inspects each byte that comes back.

Each byte moves over a simple exchange port. The engine offers a transmit byte with a valid/ready handshake, and the link returns exactly one received byte per transmitted byte. The engine always exchanges the full window of bytes that the opcode defines, and it holds only one byte in flight. At the end it pulses `done_o` with a result code. For single-word reads it also gives the 32-bit word it captured.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `tx_valid_o` are all 0.
- R2: The legal opcodes are 0xC1 to 0xCA and 0xCF. For any other opcode the engine raises `done_o` in the cycle after the start with result FAIL, and it sends no byte.
- R3: Single read (0xCA) sends the opcode and then address bytes [23:16], [15:8], [7:0]. Single write (0xC9) follows these with the write word, most significant byte first.
- R4: Internal read (0xC4) and internal write (0xC3) send two address bytes, `{addr[15] | clockless, addr[14:8]}` and then `addr[7:0]`. Internal read then adds one 0x00 byte. Internal write then sends the write word, most significant byte first.
- R5: Terminate (0xC5) and repeat (0xC6) send three 0x00 argument bytes after the opcode. Reset (0xCF) sends three 0xFF argument bytes.
- R6: DMA write and DMA read (0xC1/0xC2) send three address bytes and then length bytes [15:8], [7:0]. The extended versions (0xC7/0xC8) send three address bytes and then length bytes [23:16], [15:8], [7:0].
- R7: When CRC is enabled, one more frame byte follows the frame. It is `{crc, 1'b0}`, where crc is the 7-bit CRC of all earlier frame bytes: polynomial x^7+x^3+1 (0x09), seed 0x7F, bits fed most significant first. When CRC is disabled this byte is absent.
- R8: All bytes after the frame are 0x00. The total byte count, with F the frame length, is:
  - F+6 for 0xC5, 0xC6 and 0xCF;
  - F+10 for 0xCA and 0xC4, plus 2 when CRC is enabled;
  - F+5 for all other opcodes.
- R9: The echo byte sits at received index F+1 for 0xC5, 0xC6 and 0xCF, and at index F for all other opcodes. The echo byte must equal the opcode and the byte after it must be 0x00, otherwise the result is FAIL.
- R10: For read opcodes (0xC2, 0xC4, 0xC8, 0xCA), the bytes after the status byte are scanned for one whose upper nibble is 0xF. If no such byte arrives in the window, the result is RESET. For 0xC2 and 0xC8, finding it gives OK.
- R11: For 0xCA and 0xC4, the four bytes after the header form `rdata_o`, with the first received byte as bits [7:0]. When CRC is enabled, two CRC bytes must follow the data. If the window ends before the data bytes, or before the CRC bytes when required, the result is FAIL.
- R12: `busy_o` is high from the cycle after the start through the `done_o` cycle. `done_o` lasts exactly one cycle. The result codes are OK=0, FAIL=1 and RESET=2. While `tx_valid_o` waits for `tx_ready_i`, `tx_byte_o` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction (taken while idle) |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| wdata_i | input | 32 | Write word |
| len_i | input | 24 | Transfer length for DMA opcodes |
| crc_en_i | input | 1 | Append the CRC7 byte and expect read CRC bytes |
| clockless_i | input | 1 | Set bit 7 of the first internal address byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code, valid with done_o |
| rdata_o | output | 32 | Captured read word |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_byte_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Link accepts the transmit byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_byte_i | input | 8 | Received byte |

## Verification
A wrong byte index or a wrong frame-length decode shows directly on `tx_byte_o`. It would appear as a misplaced address, data or CRC byte, or as a nonzero filler byte, at that byte's turn on the link. A wrong window length changes the number of exchanged bytes, which can be seen before `done_o`. A parser phase stuck at the wrong point shows only at `done_o` as the wrong result code or a wrong `rdata_o`. For that reason, headers are placed at the last position the window allows and one position past it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_MAX = 9;
  localparam int IDX_W     = 5;

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_RPT     = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RST     = 8'hCF;

  typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_RESET = 2'd2} res_e;
  typedef enum logic [1:0] {K_CTRL, K_WREAD, K_DREAD, K_PLAIN} kind_e;
  typedef enum logic [2:0] {PH_PRE, PH_SEARCH, PH_DATA, PH_CRC, PH_DONE, PH_BAD} phase_e;

  function automatic logic op_legal(logic [7:0] op);
    case (op)
      OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_RPT,
      OP_XDMA_WR, OP_XDMA_RD, OP_SGL_WR, OP_SGL_RD, OP_RST: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spi_frame_build.sv
module spi_frame_build
  import spi_cmd_pkg::*;
(
  input  logic [7:0]                  opcode_i,
  input  logic [23:0]                 addr_i,
  input  logic [31:0]                 wdata_i,
  input  logic [23:0]                 len_i,
  input  logic                        clockless_i,
  output logic [FRAME_MAX-1:0][7:0]   frm_o,
  output logic [3:0]                  base_len_o,
  output kind_e                       kind_o
);
  logic [7:0] int_hi;
  assign int_hi = {addr_i[15] | clockless_i, addr_i[14:8]};

  always_comb begin
    frm_o      = '0;
    frm_o[0]   = opcode_i;
    base_len_o = 4'd4;
    kind_o     = K_PLAIN;
    case (opcode_i)
      OP_SGL_RD: begin
        frm_o[1] = addr_i[23:16]; frm_o[2] = addr_i[15:8]; frm_o[3] = addr_i[7:0];
        kind_o   = K_WREAD;
      end
      OP_SGL_WR: begin
        frm_o[1] = addr_i[23:16]; frm_o[2] = addr_i[15:8]; frm_o[3] = addr_i[7:0];
        frm_o[4] = wdata_i[31:24]; frm_o[5] = wdata_i[23:16];
        frm_o[6] = wdata_i[15:8];  frm_o[7] = wdata_i[7:0];
        base_len_o = 4'd8;
      end
      OP_INT_RD: begin
        frm_o[1] = int_hi; frm_o[2] = addr_i[7:0]; frm_o[3] = 8'h00;
        kind_o   = K_WREAD;
      end
      OP_INT_WR: begin
        frm_o[1] = int_hi; frm_o[2] = addr_i[7:0];
        frm_o[3] = wdata_i[31:24]; frm_o[4] = wdata_i[23:16];
        frm_o[5] = wdata_i[15:8];  frm_o[6] = wdata_i[7:0];
        base_len_o = 4'd7;
      end
      OP_TERM, OP_RPT: kind_o = K_CTRL;
      OP_RST: begin
        frm_o[1] = 8'hFF; frm_o[2] = 8'hFF; frm_o[3] = 8'hFF;
        kind_o   = K_CTRL;
      end
      OP_DMA_WR, OP_DMA_RD: begin
        frm_o[1] = addr_i[23:16]; frm_o[2] = addr_i[15:8]; frm_o[3] = addr_i[7:0];
        frm_o[4] = len_i[15:8];   frm_o[5] = len_i[7:0];
        base_len_o = 4'd6;
        if (opcode_i == OP_DMA_RD) kind_o = K_DREAD;
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        frm_o[1] = addr_i[23:16]; frm_o[2] = addr_i[15:8]; frm_o[3] = addr_i[7:0];
        frm_o[4] = len_i[23:16];  frm_o[5] = len_i[15:8];  frm_o[6] = len_i[7:0];
        base_len_o = 4'd7;
        if (opcode_i == OP_XDMA_RD) kind_o = K_DREAD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_crc7.sv
module spi_crc7 #(
  parameter int         N    = 8,
  parameter logic [6:0] SEED = 7'h7F,
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic [N-1:0][7:0] bytes_i,
  input  logic [3:0]        cnt_i,
  output logic [6:0]        crc_o
);
  // one update stage per byte; stage i passes through when i >= cnt_i
  logic [N:0][6:0] stage;
  assign stage[0] = SEED;

  for (genvar i = 0; i < N; i++) begin : g_byte
    logic [6:0] acc;
    always_comb begin
      acc = stage[i];
      for (int b = 7; b >= 0; b--) begin
        if (acc[6] ^ bytes_i[i][b]) acc = {acc[5:0], 1'b0} ^ POLY;
        else                        acc = {acc[5:0], 1'b0};
      end
    end
    assign stage[i+1] = (i < int'(cnt_i)) ? acc : stage[i];
  end

  assign crc_o = stage[N];
endmodule

// File: rtl/spi_rsp_check.sv
module spi_rsp_check
  import spi_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             stb_i,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] echo_pos_i,
  input  logic [7:0]       opcode_i,
  input  kind_e            kind_i,
  input  logic             crc_en_i,
  output res_e             result_o,
  output logic [31:0]      rdata_o
);
  phase_e      phase_q;
  logic [1:0]  cnt_q;
  logic [31:0] rdata_q;
  logic        is_read;

  assign is_read = (kind_i == K_WREAD) || (kind_i == K_DREAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PRE;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else if (clear_i) begin
      phase_q <= PH_PRE;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else if (stb_i) begin
      case (phase_q)
        PH_PRE: begin
          if (idx_i == echo_pos_i) begin
            if (byte_i != opcode_i) phase_q <= PH_BAD;
          end else if (idx_i == echo_pos_i + 1'b1) begin
            if (byte_i != 8'h00) phase_q <= PH_BAD;
            else                 phase_q <= is_read ? PH_SEARCH : PH_DONE;
          end
        end
        PH_SEARCH: begin
          if (byte_i[7:4] == 4'hF) begin
            phase_q <= (kind_i == K_WREAD) ? PH_DATA : PH_DONE;
            cnt_q   <= '0;
          end
        end
        PH_DATA: begin
          rdata_q <= {byte_i, rdata_q[31:8]};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == 2'd3) begin
            phase_q <= crc_en_i ? PH_CRC : PH_DONE;
            cnt_q   <= '0;
          end
        end
        PH_CRC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 2'd1) phase_q <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_DONE:   result_o = RES_OK;
      PH_SEARCH: result_o = RES_RESET;
      default:   result_o = RES_FAIL;
    endcase
  end

  assign rdata_o = rdata_q;

  // R9
  bad_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BAD && !clear_i) |=> (phase_q == PH_BAD));
  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && !clear_i) |=> (phase_q == PH_DONE));
  // R11
  data_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA || phase_q == PH_CRC) |-> (kind_i == K_WREAD));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  opcode_i,
  input  logic [23:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic [23:0] len_i,
  input  logic        crc_en_i,
  input  logic        clockless_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  result_o,
  output logic [31:0] rdata_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_byte_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_FIN} state_e;

  state_e           state_q;
  logic [7:0]       op_q;
  logic [23:0]      addr_q, len_q;
  logic [31:0]      wdata_q;
  logic             crc_q, cl_q, illegal_q;
  logic [IDX_W-1:0] idx_q;

  logic [FRAME_MAX-1:0][7:0] frm;
  logic [3:0]       base_len;
  kind_e            kind;
  logic [6:0]       crc;
  logic [IDX_W-1:0] flen, total, echo_pos;
  res_e             chk_res;
  logic             go, chk_stb;

  spi_frame_build u_build (
    .opcode_i   (op_q),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .len_i      (len_q),
    .clockless_i(cl_q),
    .frm_o      (frm),
    .base_len_o (base_len),
    .kind_o     (kind)
  );

  spi_crc7 #(.N(FRAME_MAX - 1)) u_crc (
    .bytes_i(frm[FRAME_MAX-2:0]),
    .cnt_i  (base_len),
    .crc_o  (crc)
  );

  always_comb begin
    flen = IDX_W'(base_len) + IDX_W'(crc_q);
    case (kind)
      K_CTRL:  begin total = flen + 5'd6; echo_pos = flen + 5'd1; end
      K_WREAD: begin total = flen + 5'd10 + (crc_q ? 5'd2 : 5'd0); echo_pos = flen; end
      default: begin total = flen + 5'd5; echo_pos = flen; end
    endcase
  end

  assign go      = start_i && (state_q == S_IDLE);
  assign chk_stb = (state_q == S_WAIT) && rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      len_q     <= '0;
      crc_q     <= 1'b0;
      cl_q      <= 1'b0;
      illegal_q <= 1'b0;
      idx_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q      <= opcode_i;
          addr_q    <= addr_i;
          wdata_q   <= wdata_i;
          len_q     <= len_i;
          crc_q     <= crc_en_i;
          cl_q      <= clockless_i;
          idx_q     <= '0;
          illegal_q <= !op_legal(opcode_i);
          state_q   <= op_legal(opcode_i) ? S_SEND : S_FIN;
        end
        S_SEND: if (tx_ready_i) state_q <= S_WAIT;
        S_WAIT: if (rx_valid_i) begin
          if (idx_q == total - 1'b1) state_q <= S_FIN;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_SEND;
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // frame bytes, then the CRC slot, then zero filler
  always_comb begin
    if (idx_q < IDX_W'(base_len))                     tx_byte_o = frm[idx_q[3:0]];
    else if (crc_q && idx_q == IDX_W'(base_len))      tx_byte_o = {crc, 1'b0};
    else                                              tx_byte_o = 8'h00;
  end

  spi_rsp_check u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (go),
    .stb_i     (chk_stb),
    .byte_i    (rx_byte_i),
    .idx_i     (idx_q),
    .echo_pos_i(echo_pos),
    .opcode_i  (op_q),
    .kind_i    (kind),
    .crc_en_i  (crc_q),
    .result_o  (chk_res),
    .rdata_o   (rdata_o)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign tx_valid_o = (state_q == S_SEND);

  always_comb begin
    if (!done_o)        result_o = RES_OK;
    else if (illegal_q) result_o = RES_FAIL;
    else                result_o = chk_res;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R12
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R12
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));
  // R2
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !op_legal(opcode_i)) |=> (done_o && !tx_valid_o && result_o == RES_FAIL));
  // R8
  filler_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && idx_q >= flen) |-> (tx_byte_o == 8'h00));
  // R4
  clockless_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && idx_q == 5'd1 && cl_q && (op_q == OP_INT_RD || op_q == OP_INT_WR))
      |-> tx_byte_o[7]);
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [7:0]  opcode_i;
  logic [23:0] addr_i;
  logic [31:0] wdata_i;
  logic [23:0] len_i;
  logic        crc_en_i, clockless_i;
  logic        busy_o, done_o;
  logic [1:0]  result_o;
  logic [31:0] rdata_o;
  logic        tx_valid_o;
  logic [7:0]  tx_byte_o;
  logic        tx_ready_i, rx_valid_i;
  logic [7:0]  rx_byte_i;

  always #5 clk_i = ~clk_i;

  spi_cmd_engine i_spi_cmd_engine (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_tx [32];
  logic [7:0] resp   [32];
  logic [7:0] got_tx [32];
  int got_n, exp_frame, exp_tot, exp_echo, e_g;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // link partner: accepts bytes with stalls, answers with resp[] after a variable delay
  initial begin
    tx_ready_i = 1'b0; rx_valid_i = 1'b0; rx_byte_i = 8'h00; got_n = 0;
    forever begin
      @(negedge clk_i);
      if (tx_valid_o) begin
        if (got_n % 2 == 1) @(negedge clk_i);
        if (got_n < 32) got_tx[got_n] = tx_byte_o;
        tx_ready_i = 1'b1;
        @(negedge clk_i);
        tx_ready_i = 1'b0;
        repeat (got_n % 3) @(negedge clk_i);
        rx_byte_i  = (got_n < 32) ? resp[got_n] : 8'h00;
        rx_valid_i = 1'b1;
        @(negedge clk_i);
        rx_valid_i = 1'b0;
        got_n++;
      end
    end
  end

  task automatic push(input logic [7:0] b);
    exp_tx[e_g] = b;
    e_g++;
  endtask

  task automatic build_exp(input logic [7:0] op, input logic [23:0] ad, input logic [31:0] wd,
                           input logic [23:0] ln, input bit crc, input bit cl);
    logic [6:0] c;
    for (int i = 0; i < 32; i++) exp_tx[i] = 8'h00;
    e_g = 0;
    if (!(op inside {[8'hC1:8'hCA], 8'hCF})) begin
      exp_frame = 0; exp_tot = 0; exp_echo = 0;
      return;
    end
    push(op);
    if (op inside {8'hC1, 8'hC2, 8'hC7, 8'hC8, 8'hC9, 8'hCA}) begin
      push(ad[23:16]); push(ad[15:8]); push(ad[7:0]);
    end
    if (op inside {8'hC3, 8'hC4}) begin
      push({ad[15] | cl, ad[14:8]}); push(ad[7:0]);
    end
    if (op == 8'hC4) push(8'h00);
    if (op inside {8'hC5, 8'hC6}) begin push(8'h00); push(8'h00); push(8'h00); end
    if (op == 8'hCF) begin push(8'hFF); push(8'hFF); push(8'hFF); end
    if (op inside {8'hC1, 8'hC2}) begin push(ln[15:8]); push(ln[7:0]); end
    if (op inside {8'hC7, 8'hC8}) begin push(ln[23:16]); push(ln[15:8]); push(ln[7:0]); end
    if (op inside {8'hC3, 8'hC9}) begin
      push(wd[31:24]); push(wd[23:16]); push(wd[15:8]); push(wd[7:0]);
    end
    if (crc) begin
      c = 7'h7F;
      for (int i = 0; i < e_g; i++)
        for (int b = 7; b >= 0; b--) begin
          logic fb;
          fb = c[6] ^ exp_tx[i][b];
          c  = {c[5:0], 1'b0};
          if (fb) c = c ^ 7'h09;
        end
      push({c, 1'b0});
    end
    exp_frame = e_g;
    if (op inside {8'hC5, 8'hC6, 8'hCF}) begin
      exp_tot = exp_frame + 6; exp_echo = exp_frame + 1;
    end else if (op inside {8'hC4, 8'hCA}) begin
      exp_tot = exp_frame + 10 + (crc ? 2 : 0); exp_echo = exp_frame;
    end else begin
      exp_tot = exp_frame + 5; exp_echo = exp_frame;
    end
  endtask

  task automatic prep_resp(input logic [7:0] echo, input logic [7:0] status);
    for (int i = 0; i < 32; i++) resp[i] = 8'h11;
    resp[exp_echo]     = echo;
    resp[exp_echo + 1] = status;
  endtask

  task automatic txn(input string req, input logic [7:0] op, input logic [23:0] ad,
                     input logic [31:0] wd, input logic [23:0] ln, input bit crc, input bit cl,
                     input logic [1:0] exp_res, input bit chk_rd, input logic [31:0] exp_rd);
    int t;
    int bad;
    build_exp(op, ad, wd, ln, crc, cl);
    got_n = 0;
    @(negedge clk_i);
    opcode_i = op; addr_i = ad; wdata_i = wd; len_i = ln;
    crc_en_i = crc; clockless_i = cl; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R12", "busy after start", 32'(busy_o), 32'd1);
    t = 0;
    while (!done_o && t < 2000) begin @(negedge clk_i); t++; end
    chk(t < 2000, "R12", "done timeout", t, 0);
    chk(result_o == exp_res, req, "result", 32'(result_o), 32'(exp_res));
    if (chk_rd) chk(rdata_o == exp_rd, "R11", "read word", rdata_o, exp_rd);
    chk(got_n == exp_tot, "R8", "byte count", got_n, exp_tot);
    bad = -1;
    for (int i = 0; i < exp_tot && i < got_n; i++)
      if (bad < 0 && got_tx[i] !== exp_tx[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, $sformatf("tx byte %0d", bad), 32'(got_tx[bad]), 32'(exp_tx[bad]));
    else          chk(1'b1, req, "tx bytes", 0, 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R12", "done one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic t_reset_state;
    chk(!busy_o && !done_o && !tx_valid_o, "R1", "reset outputs",
        {29'd0, busy_o, done_o, tx_valid_o}, 32'd0);
  endtask

  task automatic t_single_write;  // R3 R7
    build_exp(8'hC9, 24'h123456, 32'hDEADBEEF, 0, 1, 0);
    prep_resp(8'hC9, 8'h00);
    txn("R3", 8'hC9, 24'h123456, 32'hDEADBEEF, 0, 1, 0, 2'd0, 0, 0);
    chk(exp_frame == 9, "R7", "frame with crc", exp_frame, 9);
  endtask

  task automatic t_single_read_crc;  // R10 R11 R7
    build_exp(8'hCA, 24'hA0B0C0, 0, 0, 1, 0);
    prep_resp(8'hCA, 8'h00);
    resp[exp_echo + 2] = 8'hF3;
    resp[exp_echo + 3] = 8'h78; resp[exp_echo + 4] = 8'h56;
    resp[exp_echo + 5] = 8'h34; resp[exp_echo + 6] = 8'h12;
    txn("R7", 8'hCA, 24'hA0B0C0, 0, 0, 1, 0, 2'd0, 1, 32'h12345678);
  endtask

  task automatic t_single_read_late;  // R11 header at last legal slot, CRC off
    build_exp(8'hCA, 24'h000104, 0, 0, 0, 0);
    prep_resp(8'hCA, 8'h00);
    resp[exp_echo + 5] = 8'hF0;
    resp[exp_echo + 6] = 8'hEF; resp[exp_echo + 7] = 8'hBE;
    resp[exp_echo + 8] = 8'hAD; resp[exp_echo + 9] = 8'hDE;
    txn("R11", 8'hCA, 24'h000104, 0, 0, 0, 0, 2'd0, 1, 32'hDEADBEEF);
  endtask

  task automatic t_int_read_overrun;  // R4 R11
    build_exp(8'hC4, 24'h000024, 0, 0, 0, 1);
    prep_resp(8'hC4, 8'h00);
    resp[exp_echo + 6] = 8'hFF;
    txn("R11", 8'hC4, 24'h000024, 0, 0, 0, 1, 2'd1, 0, 0);
    chk(got_tx[1][7] == 1'b1, "R4", "clockless bit", 32'(got_tx[1]), 32'h80);
  endtask

  task automatic t_single_read_crc_overrun;  // R11 CRC bytes do not fit
    build_exp(8'hCA, 24'h000010, 0, 0, 1, 0);
    prep_resp(8'hCA, 8'h00);
    resp[exp_echo + 6] = 8'hF1;
    txn("R11", 8'hCA, 24'h000010, 0, 0, 1, 0, 2'd1, 0, 0);
  endtask

  task automatic t_int_write;  // R4
    build_exp(8'hC3, 24'h00ABCD, 32'h01020304, 0, 1, 0);
    prep_resp(8'hC3, 8'h00);
    txn("R4", 8'hC3, 24'h00ABCD, 32'h01020304, 0, 1, 0, 2'd0, 0, 0);
  endtask

  task automatic t_reset_op;  // R5 R9
    build_exp(8'hCF, 0, 0, 0, 1, 0);
    prep_resp(8'hCF, 8'h00);
    resp[exp_echo - 1] = 8'hCF;
    txn("R5", 8'hCF, 0, 0, 0, 1, 0, 2'd0, 0, 0);
    chk(exp_echo == exp_frame + 1, "R9", "skip byte", exp_echo, exp_frame + 1);
  endtask

  task automatic t_term_bad_echo;  // R9
    build_exp(8'hC5, 0, 0, 0, 0, 0);
    prep_resp(8'hC4, 8'h00);
    txn("R9", 8'hC5, 0, 0, 0, 0, 0, 2'd1, 0, 0);
  endtask

  task automatic t_repeat_bad_status;  // R9 R5
    build_exp(8'hC6, 0, 0, 0, 1, 0);
    prep_resp(8'hC6, 8'h01);
    txn("R9", 8'hC6, 0, 0, 0, 1, 0, 2'd1, 0, 0);
  endtask

  task automatic t_dma_read_noheader;  // R10 R6
    build_exp(8'hC2, 24'h345678, 0, 24'h000123, 1, 0);
    prep_resp(8'hC2, 8'h00);
    txn("R10", 8'hC2, 24'h345678, 0, 24'h000123, 1, 0, 2'd2, 0, 0);
  endtask

  task automatic t_dma_read_header;  // R10
    build_exp(8'hC2, 24'h000001, 0, 24'h000800, 0, 0);
    prep_resp(8'hC2, 8'h00);
    resp[exp_tot - 1] = 8'hF8;
    txn("R10", 8'hC2, 24'h000001, 0, 24'h000800, 0, 0, 2'd0, 0, 0);
  endtask

  task automatic t_xdma_write;  // R6
    build_exp(8'hC7, 24'h102030, 0, 24'hABCDEF, 0, 0);
    prep_resp(8'hC7, 8'h00);
    txn("R6", 8'hC7, 24'h102030, 0, 24'hABCDEF, 0, 0, 2'd0, 0, 0);
  endtask

  task automatic t_illegal;  // R2
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
    txn("R2", 8'hC0, 24'h1, 0, 0, 1, 0, 2'd1, 0, 0);
    chk(got_n == 0, "R2", "no bytes sent", got_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; opcode_i = 0; addr_i = 0; wdata_i = 0; len_i = 0;
    crc_en_i = 0; clockless_i = 0;
    repeat (3) @(negedge clk_i);
    t_reset_state();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_single_write();
    t_single_read_crc();
    t_single_read_late();
    t_int_read_overrun();
    t_single_read_crc_overrun();
    t_int_write();
    t_reset_op();
    t_term_bad_echo();
    t_repeat_bad_status();
    t_dma_read_noheader();
    t_dma_read_header();
    t_xdma_write();
    t_illegal();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule